// File: doc/BRIEF.md
# Vector Floating-Point Status and Control Register

This block holds the 128-bit status and control state of a four-lane SIMD floating-point unit. The state is split into four 32-bit words. Software replaces the whole register in one cycle, and each word passes through a fixed keep-mask. Software reads all 128 bits back, with word 3 in the most significant position.

The arithmetic datapath uses the same state through three narrow ports:

- Two double-precision lanes each own a 2-bit rounding-mode field in word 3. The datapath writes and reads those fields through a lane-indexed port.
- Single-precision lanes raise overflow, underflow, non-IEEE-result and divide-by-zero flags.
- Double-precision lanes raise overflow, underflow, inexact, invalid, NaN and denormal flags.

Every flag is sticky. Only a software write or reset clears a flag. All update sources may be active in the same cycle, and their effects are merged into one next state.

Top module: `vfp_status_reg`

## Requirements
- R1: An active-low asynchronous reset clears all 128 bits, so the read port shows zero.
- R2: A software write stores each word ANDed with a keep-mask. Words 0 and 3 use 0x00000F07, and words 1 and 2 use 0x00003F07. The read port carries word 3 on bits [127:96] and word 0 on bits [31:0], and shows the new value after the clock edge.
- R3: A rounding write for double lane s (0 or 1) replaces only bits [9+2s:8+2s] of word 3. The mode codes are 0 = nearest even, 1 = toward zero, 2 = toward +infinity and 3 = toward -infinity.
- R4: The rounding read port returns the stored 2-bit field for the requested lane without a clock delay. It returns 0 for a lane index of 2 or above.
- R5: A single-precision flag event for lane n (0..3) ORs its 3-bit vector into word n, bits [2:0]. Bit 2 is overflow, bit 1 is underflow and bit 0 is non-IEEE result.
- R6: A divide-by-zero event for single lane n sets bit 8+n of word 0.
- R7: A double-precision flag event for lane s ORs a 6-bit vector into word 1+s, bits [13:8]. The vector is {overflow, underflow, inexact, invalid, NaN, denormal}, with overflow landing on bit 13.
- R8: Flags are sticky: without a software write or reset, no flag bit that is set ever clears.
- R9: When a software write and flag events fall in the same cycle, the masked write value is stored first and the flags are ORed on top.
- R10: All ports active in one cycle are merged bitwise, and a rounding write overrides the software write value in its two bits.
- R11: A lane index that is out of range has no effect on the register. For single precision and divide-by-zero that is above 3. For double precision and rounding writes it is above 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 128 | Software write value, word 3 in the top bits |
| sw_rdata | output | 128 | Full stored register |
| rnd_we | input | 1 | Rounding-mode write strobe |
| rnd_lane | input | 2 | Double lane index for the rounding write |
| rnd_mode | input | 2 | Rounding-mode code to store |
| rnd_rd_lane | input | 2 | Double lane index for the rounding read |
| rnd_rd_mode | output | 2 | Rounding mode of the selected lane |
| sp_set | input | 1 | Single-precision flag event |
| sp_lane | input | 3 | Single lane index |
| sp_flags | input | 3 | {overflow, underflow, non-IEEE} |
| dz_set | input | 1 | Divide-by-zero event |
| dz_lane | input | 3 | Single lane index for divide-by-zero |
| dp_set | input | 1 | Double-precision flag event |
| dp_lane | input | 2 | Double lane index |
| dp_flags | input | 6 | {ovf, unf, inexact, invalid, NaN, denormal} |

## Verification
- **Software write patterns.** Writes of all ones, of a mixed pattern and of all zeros show that each word gets its own mask. Only the two middle words keep bits 13:12.
- **Flag events.** Flag events come one at a time, and each uses a different lane and flag pattern. Each one must land in exactly its own word and bit range, while earlier flags stay set.
- **Rounding writes.** A series of rounding writes checks that one lane's field is rewritten without disturbing the neighbouring lane's field.
- **Collisions and bad indices.** In one cycle, every index is out of range, which must leave the register unchanged. In another, every port fires together with a software write, which checks the ordering of write, OR and rounding override.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   localparam int unsigned FSR_WORD_W  = 32;
   localparam int unsigned FSR_N_WORDS = 4;
   localparam int unsigned FSR_DP_LANES = 2;
   localparam logic [31:0] FSR_MASK_EDGE = 32'h0000_0F07;
   localparam logic [31:0] FSR_MASK_MID  = 32'h0000_3F07;
   localparam int unsigned FSR_SP_FW  = 3;
   localparam int unsigned FSR_DP_FW  = 6;
   localparam int unsigned FSR_DP_LSB = 8;
   localparam int unsigned FSR_DZ_LSB = 8;
   localparam int unsigned FSR_RND_LSB = 8;
   localparam int unsigned FSR_RND_W  = 2;

   typedef enum logic [1:0] {
      RND_NEAR_EVEN = 2'd0,
      RND_ZERO      = 2'd1,
      RND_POS_INF   = 2'd2,
      RND_NEG_INF   = 2'd3
   } rnd_mode_e;
endpackage

// File: rtl/fsr_wmask.sv
module fsr_wmask #(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned N_WORDS   = 4,
   parameter logic [31:0] MASK_EDGE = 32'h0000_0F07,
   parameter logic [31:0] MASK_MID  = 32'h0000_3F07,
   localparam int unsigned REG_W    = WORD_W * N_WORDS
) (
   input  logic [REG_W-1:0] din,
   output logic [REG_W-1:0] dout,
   output logic [REG_W-1:0] keep
);
   if (WORD_W > 32) begin : g_bad_width
      $error("fsr_wmask: WORD_W above 32 not supported");
   end

   for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      if (w == 0 || w == N_WORDS - 1) begin : g_edge
         assign keep[w*WORD_W +: WORD_W] = MASK_EDGE[WORD_W-1:0];
      end else begin : g_mid
         assign keep[w*WORD_W +: WORD_W] = MASK_MID[WORD_W-1:0];
      end
      assign dout[w*WORD_W +: WORD_W] = din[w*WORD_W +: WORD_W] & keep[w*WORD_W +: WORD_W];
   end
endmodule

// File: rtl/fsr_flag_route.sv
module fsr_flag_route #(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned N_WORDS  = 4,
   parameter int unsigned DP_LANES = 2,
   parameter int unsigned SP_FW    = 3,
   parameter int unsigned DP_FW    = 6,
   parameter int unsigned DP_LSB   = 8,
   parameter int unsigned DZ_LSB   = 8,
   localparam int unsigned REG_W   = WORD_W * N_WORDS,
   localparam int unsigned SPI_W   = $clog2(N_WORDS) + 1,
   localparam int unsigned DPI_W   = $clog2(DP_LANES) + 1
) (
   input  logic             sp_set,
   input  logic [SPI_W-1:0] sp_lane,
   input  logic [SP_FW-1:0] sp_flags,
   input  logic             dz_set,
   input  logic [SPI_W-1:0] dz_lane,
   input  logic             dp_set,
   input  logic [DPI_W-1:0] dp_lane,
   input  logic [DP_FW-1:0] dp_flags,
   output logic [REG_W-1:0] set_bits
);
   logic [REG_W-1:0] sp_part, dz_part, dp_part;

   for (genvar n = 0; n < N_WORDS; n++) begin : g_sp
      wire sp_hit = sp_set && (sp_lane == SPI_W'(n));
      wire dz_hit = dz_set && (dz_lane == SPI_W'(n));
      assign sp_part[n*WORD_W +: WORD_W] =
         sp_hit ? WORD_W'(sp_flags) : '0;
      if (n == 0) begin : g_dz_word
         always_comb begin
            dz_part[WORD_W-1:0] = '0;
            for (int k = 0; k < N_WORDS; k++)
               if (dz_set && dz_lane == SPI_W'(k))
                  dz_part[DZ_LSB + k] = 1'b1;
         end
      end else begin : g_dz_none
         assign dz_part[n*WORD_W +: WORD_W] = '0;
      end
      if (n >= 1 && n <= DP_LANES) begin : g_dp_word
         assign dp_part[n*WORD_W +: WORD_W] =
            (dp_set && dp_lane == DPI_W'(n - 1)) ? (WORD_W'(dp_flags) << DP_LSB) : '0;
      end else begin : g_dp_none
         assign dp_part[n*WORD_W +: WORD_W] = '0;
      end
      logic unused_dz_hit;
      assign unused_dz_hit = dz_hit;
   end

   assign set_bits = sp_part | dz_part | dp_part;
endmodule

// File: rtl/fsr_rnd_field.sv
module fsr_rnd_field #(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned DP_LANES = 2,
   parameter int unsigned RND_LSB  = 8,
   parameter int unsigned RND_W    = 2,
   localparam int unsigned DPI_W   = $clog2(DP_LANES) + 1
) (
   input  logic              wr_en,
   input  logic [DPI_W-1:0]  wr_lane,
   input  logic [RND_W-1:0]  wr_mode,
   input  logic [DPI_W-1:0]  rd_lane,
   input  logic [WORD_W-1:0] cur_word,
   output logic [WORD_W-1:0] fld_mask,
   output logic [WORD_W-1:0] fld_val,
   output logic [RND_W-1:0]  rd_mode
);
   always_comb begin
      fld_mask = '0;
      fld_val  = '0;
      rd_mode  = '0;
      for (int s = 0; s < DP_LANES; s++) begin
         if (wr_en && wr_lane == DPI_W'(s)) begin
            fld_mask[RND_LSB + s*RND_W +: RND_W] = '1;
            fld_val [RND_LSB + s*RND_W +: RND_W] = wr_mode;
         end
         if (rd_lane == DPI_W'(s))
            rd_mode = cur_word[RND_LSB + s*RND_W +: RND_W];
      end
   end
endmodule

// File: rtl/vfp_status_reg.sv
module vfp_status_reg
   import fsr_pkg::*;
#(
   parameter int unsigned WORD_W    = FSR_WORD_W,
   parameter int unsigned N_WORDS   = FSR_N_WORDS,
   parameter int unsigned DP_LANES  = FSR_DP_LANES,
   parameter logic [31:0] MASK_EDGE = FSR_MASK_EDGE,
   parameter logic [31:0] MASK_MID  = FSR_MASK_MID,
   parameter int unsigned SP_FW     = FSR_SP_FW,
   parameter int unsigned DP_FW     = FSR_DP_FW,
   parameter int unsigned DP_LSB    = FSR_DP_LSB,
   parameter int unsigned DZ_LSB    = FSR_DZ_LSB,
   parameter int unsigned RND_LSB   = FSR_RND_LSB,
   parameter int unsigned RND_W     = FSR_RND_W,
   localparam int unsigned REG_W    = WORD_W * N_WORDS,
   localparam int unsigned SPI_W    = $clog2(N_WORDS) + 1,
   localparam int unsigned DPI_W    = $clog2(DP_LANES) + 1,
   localparam int unsigned TOP_LSB  = (N_WORDS - 1) * WORD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_we,
   input  logic [REG_W-1:0] sw_wdata,
   output logic [REG_W-1:0] sw_rdata,
   input  logic             rnd_we,
   input  logic [DPI_W-1:0] rnd_lane,
   input  logic [RND_W-1:0] rnd_mode,
   input  logic [DPI_W-1:0] rnd_rd_lane,
   output logic [RND_W-1:0] rnd_rd_mode,
   input  logic             sp_set,
   input  logic [SPI_W-1:0] sp_lane,
   input  logic [SP_FW-1:0] sp_flags,
   input  logic             dz_set,
   input  logic [SPI_W-1:0] dz_lane,
   input  logic             dp_set,
   input  logic [DPI_W-1:0] dp_lane,
   input  logic [DP_FW-1:0] dp_flags
);
   if (N_WORDS < DP_LANES + 1) begin : g_chk_words
      $error("vfp_status_reg: too few words for the double lanes");
   end
   if (DP_LSB + DP_FW > WORD_W || DZ_LSB + N_WORDS > WORD_W ||
       RND_LSB + RND_W * DP_LANES > WORD_W) begin : g_chk_fields
      $error("vfp_status_reg: field does not fit in a word");
   end
   if (SP_FW > DP_LSB) begin : g_chk_overlap
      $error("vfp_status_reg: single flags overlap double flags");
   end

   logic [REG_W-1:0]  state, nxt, wr_masked, keep, set_bits, base;
   logic [WORD_W-1:0] fld_mask, fld_val;

   fsr_wmask #(.WORD_W(WORD_W), .N_WORDS(N_WORDS),
               .MASK_EDGE(MASK_EDGE), .MASK_MID(MASK_MID)) u_wmask (
      .din(sw_wdata), .dout(wr_masked), .keep(keep));

   fsr_flag_route #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .DP_LANES(DP_LANES),
                    .SP_FW(SP_FW), .DP_FW(DP_FW), .DP_LSB(DP_LSB),
                    .DZ_LSB(DZ_LSB)) u_route (
      .sp_set(sp_set), .sp_lane(sp_lane), .sp_flags(sp_flags),
      .dz_set(dz_set), .dz_lane(dz_lane),
      .dp_set(dp_set), .dp_lane(dp_lane), .dp_flags(dp_flags),
      .set_bits(set_bits));

   fsr_rnd_field #(.WORD_W(WORD_W), .DP_LANES(DP_LANES),
                   .RND_LSB(RND_LSB), .RND_W(RND_W)) u_rnd (
      .wr_en(rnd_we), .wr_lane(rnd_lane), .wr_mode(rnd_mode),
      .rd_lane(rnd_rd_lane), .cur_word(state[TOP_LSB +: WORD_W]),
      .fld_mask(fld_mask), .fld_val(fld_val), .rd_mode(rnd_rd_mode));

   // write first, sticky OR next, rounding field last
   assign base = sw_we ? wr_masked : state;
   assign nxt  = ((base | set_bits) & ~(REG_W'(fld_mask) << TOP_LSB))
               | (REG_W'(fld_val) << TOP_LSB);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= '0;
      else        state <= nxt;
   end

   assign sw_rdata = state;

   localparam logic [REG_W-1:0] RND_ALL =
      REG_W'({(RND_W * DP_LANES){1'b1}}) << (TOP_LSB + RND_LSB);

   // R2
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state & ~keep) == '0);

   // R8
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_we |=> (($past(state) & ~RND_ALL & ~state) == '0));

   // R3
   rnd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rnd_we && rnd_lane < DPI_W'(DP_LANES)) |=>
      (state[TOP_LSB + RND_LSB + int'($past(rnd_lane)) * RND_W +: RND_W] == $past(rnd_mode)));

   // R5
   sp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_set && sp_lane < SPI_W'(N_WORDS)) |=>
      ((state[int'($past(sp_lane)) * WORD_W +: SP_FW] & $past(sp_flags)) == $past(sp_flags)));

   // R7
   dp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_set && dp_lane < DPI_W'(DP_LANES)) |=>
      ((state[(int'($past(dp_lane)) + 1) * WORD_W + DP_LSB +: DP_FW] & $past(dp_flags))
        == $past(dp_flags)));

   // R11
   oob_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_we && !rnd_we && !dz_set && !dp_set && sp_set && sp_lane >= SPI_W'(N_WORDS))
      |=> (state == $past(state)));
endmodule

// File: tb/sim_vfp_status_reg.sv
module sim_vfp_status_reg;
   typedef struct packed {
      logic         sw_we;
      logic [127:0] wdata;
      logic         rnd_we;
      logic [1:0]   rnd_lane;
      logic [1:0]   rnd_mode;
      logic         sp_set;
      logic [2:0]   sp_lane;
      logic [2:0]   sp_flags;
      logic         dz_set;
      logic [2:0]   dz_lane;
      logic         dp_set;
      logic [1:0]   dp_lane;
      logic [5:0]   dp_flags;
      logic [127:0] exp;
      logic [3:0]   req;
   } vec_t;

   localparam logic [127:0] ONES = {128{1'b1}};
   localparam logic [127:0] ZERO = 128'h0;
   localparam int NV = 14;
   localparam vec_t TBL [NV] = '{
      // R2 all ones through the masks
      '{1'b1, ONES, 1'b0, 2'd0, 2'd0, 1'b0, 3'd0, 3'd0, 1'b0, 3'd0, 1'b0, 2'd0, 6'd0,
        128'h00000F07_00003F07_00003F07_00000F07, 4'd2},
      // R2 mixed pattern
      '{1'b1, 128'h12345678_9ABCDEF0_0F0F0F0F_F0F0F0F0, 1'b0, 2'd0, 2'd0, 1'b0, 3'd0, 3'd0,
        1'b0, 3'd0, 1'b0, 2'd0, 6'd0, 128'h00000600_00001E00_00000F07_00000000, 4'd2},
      // R2 clear
      '{1'b1, ZERO, 1'b0, 2'd0, 2'd0, 1'b0, 3'd0, 3'd0, 1'b0, 3'd0, 1'b0, 2'd0, 6'd0,
        ZERO, 4'd2},
      // R5 single lane 2 ovf+diff
      '{1'b0, ZERO, 1'b0, 2'd0, 2'd0, 1'b1, 3'd2, 3'b101, 1'b0, 3'd0, 1'b0, 2'd0, 6'd0,
        128'h00000000_00000005_00000000_00000000, 4'd5},
      // R8 lane 0 underflow, lane 2 stays
      '{1'b0, ZERO, 1'b0, 2'd0, 2'd0, 1'b1, 3'd0, 3'b010, 1'b0, 3'd0, 1'b0, 2'd0, 6'd0,
        128'h00000000_00000005_00000000_00000002, 4'd8},
      // R6 divide-by-zero lane 3
      '{1'b0, ZERO, 1'b0, 2'd0, 2'd0, 1'b0, 3'd0, 3'd0, 1'b1, 3'd3, 1'b0, 2'd0, 6'd0,
        128'h00000000_00000005_00000000_00000802, 4'd6},
      // R7 double lane 1 ovf+denorm
      '{1'b0, ZERO, 1'b0, 2'd0, 2'd0, 1'b0, 3'd0, 3'd0, 1'b0, 3'd0, 1'b1, 2'd1, 6'b100001,
        128'h00000000_00002105_00000000_00000802, 4'd7},
      // R7 double lane 0 unf..nan
      '{1'b0, ZERO, 1'b0, 2'd0, 2'd0, 1'b0, 3'd0, 3'd0, 1'b0, 3'd0, 1'b1, 2'd0, 6'b011110,
        128'h00000000_00002105_00001E00_00000802, 4'd7},
      // R3 lane 1 toward -inf
      '{1'b0, ZERO, 1'b1, 2'd1, 2'd3, 1'b0, 3'd0, 3'd0, 1'b0, 3'd0, 1'b0, 2'd0, 6'd0,
        128'h00000C00_00002105_00001E00_00000802, 4'd3},
      // R3 lane 0 toward +inf
      '{1'b0, ZERO, 1'b1, 2'd0, 2'd2, 1'b0, 3'd0, 3'd0, 1'b0, 3'd0, 1'b0, 2'd0, 6'd0,
        128'h00000E00_00002105_00001E00_00000802, 4'd3},
      // R3 lane 1 back to nearest even, lane 0 kept
      '{1'b0, ZERO, 1'b1, 2'd1, 2'd0, 1'b0, 3'd0, 3'd0, 1'b0, 3'd0, 1'b0, 2'd0, 6'd0,
        128'h00000200_00002105_00001E00_00000802, 4'd3},
      // R11 every index out of range
      '{1'b0, ZERO, 1'b1, 2'd3, 2'd3, 1'b1, 3'd4, 3'b111, 1'b1, 3'd5, 1'b1, 2'd2, 6'h3F,
        128'h00000200_00002105_00001E00_00000802, 4'd11},
      // R9 write zero with all flag ports in the same cycle
      '{1'b1, ZERO, 1'b1, 2'd0, 2'd1, 1'b1, 3'd1, 3'b100, 1'b1, 3'd0, 1'b1, 2'd1, 6'h3F,
        128'h00000100_00003F00_00000004_00000100, 4'd9},
      // R10 rounding beats write value
      '{1'b1, ONES, 1'b1, 2'd1, 2'd1, 1'b0, 3'd0, 3'd0, 1'b0, 3'd0, 1'b0, 2'd0, 6'd0,
        128'h00000707_00003F07_00003F07_00000F07, 4'd10}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic sw_we = 1'b0, rnd_we = 1'b0, sp_set = 1'b0, dz_set = 1'b0, dp_set = 1'b0;
   logic [127:0] sw_wdata = '0, sw_rdata;
   logic [1:0] rnd_lane = '0, rnd_mode = '0, rnd_rd_lane = '0, rnd_rd_mode, dp_lane = '0;
   logic [2:0] sp_lane = '0, sp_flags = '0, dz_lane = '0;
   logic [5:0] dp_flags = '0;
   int errors = 0, checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   vfp_status_reg u0 (
      .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
      .rnd_we(rnd_we), .rnd_lane(rnd_lane), .rnd_mode(rnd_mode),
      .rnd_rd_lane(rnd_rd_lane), .rnd_rd_mode(rnd_rd_mode),
      .sp_set(sp_set), .sp_lane(sp_lane), .sp_flags(sp_flags),
      .dz_set(dz_set), .dz_lane(dz_lane),
      .dp_set(dp_set), .dp_lane(dp_lane), .dp_flags(dp_flags));

   task automatic check128(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check2(input string req, input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle();
      sw_we = 0; rnd_we = 0; sp_set = 0; dz_set = 0; dp_set = 0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check128("R1 in reset", sw_rdata, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check128("R1 after release", sw_rdata, '0);
      for (int i = 0; i < NV; i++) begin
         sw_we = TBL[i].sw_we;   sw_wdata = TBL[i].wdata;
         rnd_we = TBL[i].rnd_we; rnd_lane = TBL[i].rnd_lane; rnd_mode = TBL[i].rnd_mode;
         sp_set = TBL[i].sp_set; sp_lane = TBL[i].sp_lane;   sp_flags = TBL[i].sp_flags;
         dz_set = TBL[i].dz_set; dz_lane = TBL[i].dz_lane;
         dp_set = TBL[i].dp_set; dp_lane = TBL[i].dp_lane;   dp_flags = TBL[i].dp_flags;
         @(negedge clk);
         idle();
         check128($sformatf("R%0d vector %0d", TBL[i].req, i), sw_rdata, TBL[i].exp);
      end
      // R4 combinational rounding read, state word 3 = 0x707
      rnd_rd_lane = 2'd0; #1 check2("R4 lane 0", rnd_rd_mode, 2'd3);
      rnd_rd_lane = 2'd1; #1 check2("R4 lane 1", rnd_rd_mode, 2'd1);
      rnd_rd_lane = 2'd2; #1 check2("R4 lane 2 out of range", rnd_rd_mode, 2'd0);
      // R8 idle cycle keeps everything
      @(negedge clk);
      check128("R8 idle hold", sw_rdata, 128'h00000707_00003F07_00003F07_00000F07);
      // R1 asynchronous reset mid-run
      rst_n = 1'b0; #1;
      check128("R1 async clear", sw_rdata, '0);
      @(negedge clk);
      rst_n = 1'b1;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule